// File: doc/BRIEF.md
# Boot Stream Chunk Loader

This block takes the boot image of a signal processor as a stream of 24-bit words and turns it into write cycles on three separate memories: program memory, X data memory and Y data memory. It sits between a host-side word source, which offers one word at a time over a valid/ready handshake, and the three memory write ports. It stops when the stream asks for a jump to an entry point.

The stream opens with a loader preamble. That is a word count, then a start address, then that many words for program memory. After the preamble come tagged chunks. Each chunk holds a command word, a destination address and a word count, then its data. The command picks the target memory. One command packs two 12-bit values into each data word for Y memory. Another command ends loading and reports the entry address. Any command code the block does not know halts it with a sticky error.

Every memory write is registered. It appears on the write port one clock after the stream word that caused it was accepted. The three write ports share one address and data register, and only the write enable tells which memory is addressed.

Top module: `boot_chunk_loader`

## Requirements
- R1: After reset, no write enable is active, `s_ready` is high, and `done` and `err` are low.
- R2: The first word gives a count N and the second a start address A. The next N words are written to program memory at A, A+1, and so on up to A+N-1.
- R3: A preamble count of zero sends the next stream word straight to command decoding, with no program write.
- R4: The command codes 0, 1 and 2 select program, X and Y memory. The chunk's data words go to consecutive addresses starting at the chunk's address word.
- R5: Command code 3 writes to Y memory in split mode. Each data word makes two writes. The first write is bits 23:12 at the current address, and the second is bits 11:0 at the next address. Each value is zero-extended into bits 11:0 of the written word. `s_ready` is low for the cycle that the second write needs.
- R6: Command code 4 takes only an address word, which has no size word after it. Once that word is accepted, `done` goes high and stays high, `entry_addr` holds that word, and `s_ready` stays low. No further writes occur.
- R7: A command code above 4 raises `err`, which stays high. It also holds `s_ready` low and stops all writes.
- R8: A chunk with a size of zero is followed directly by the next command word.
- R9: Each write appears one cycle after the accepting clock edge, and at most one of the three write enables is high in any cycle.
- R10: While `s_valid` is low the parser does not advance, so idle gaps in the stream do not change the write sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream word offered |
| s_data | input | 24 | Stream word |
| s_ready | output | 1 | Loader can accept a word this cycle |
| p_we | output | 1 | Program memory write enable |
| p_addr | output | 24 | Program memory write address |
| p_wdata | output | 24 | Program memory write data |
| x_we | output | 1 | X memory write enable |
| x_addr | output | 24 | X memory write address |
| x_wdata | output | 24 | X memory write data |
| y_we | output | 1 | Y memory write enable |
| y_addr | output | 24 | Y memory write address |
| y_wdata | output | 24 | Y memory write data |
| done | output | 1 | Jump command seen, loading ended |
| entry_addr | output | 24 | Entry address carried by the jump command |
| err | output | 1 | Sticky error from an unknown command code |

## Verification
The bench aims at the chunk edges. A zero-size chunk that wrongly used the next command word as data would shift every later write onto the wrong memory. A preamble of size zero that was mishandled would load the first command into program memory. Split mode is checked for half order and zero extension, and for the one-cycle stall on `s_ready`. A design that swapped the halves, or kept accepting input during the second half, would write wrong Y values or lose a stream word. After the jump and after an unknown command, extra words are offered to show that nothing more is accepted or written. Gaps in `s_valid` are mixed into the main stream to show that the parser only advances on a handshake.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

    typedef enum logic [2:0] {
        ST_PSIZE,
        ST_POFF,
        ST_CMD,
        ST_ADDR,
        ST_SIZE,
        ST_DATA,
        ST_SPLO,
        ST_HALT
    } ldr_st_e;

    typedef enum logic [1:0] {
        TGT_P,
        TGT_X,
        TGT_Y,
        TGT_YS
    } ldr_tgt_e;

    localparam int unsigned CMD_JUMP = 4;

endpackage

// File: rtl/bl_cmd_decode.sv
module bl_cmd_decode
    import boot_ldr_pkg::*;
#(
    parameter int unsigned DW = 24
) (
    input  logic [DW-1:0] cmd,
    output ldr_tgt_e      tgt,
    output logic          is_jump,
    output logic          is_bad
);
    always_comb begin
        is_jump = (cmd == DW'(CMD_JUMP));
        is_bad  = (cmd > DW'(CMD_JUMP));
        case (cmd[1:0])
            2'd0:    tgt = TGT_P;
            2'd1:    tgt = TGT_X;
            2'd2:    tgt = TGT_Y;
            default: tgt = TGT_YS;
        endcase
    end
endmodule

// File: rtl/bl_word_split.sv
module bl_word_split #(
    parameter int unsigned DW = 24
) (
    input  logic [DW-1:0] word,
    output logic [DW-1:0] hi_half,
    output logic [DW-1:0] lo_half
);
    localparam int unsigned HW = DW / 2;

    always_comb begin
        hi_half = '0;
        lo_half = '0;
        hi_half[DW-HW-1:0] = word[DW-1:HW];
        lo_half[HW-1:0]    = word[HW-1:0];
    end
endmodule

// File: rtl/boot_chunk_loader.sv
module boot_chunk_loader
    import boot_ldr_pkg::*;
#(
    parameter int unsigned DW = 24,
    parameter int unsigned AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    output logic          s_ready,
    output logic          p_we,
    output logic [AW-1:0] p_addr,
    output logic [DW-1:0] p_wdata,
    output logic          x_we,
    output logic [AW-1:0] x_addr,
    output logic [DW-1:0] x_wdata,
    output logic          y_we,
    output logic [AW-1:0] y_addr,
    output logic [DW-1:0] y_wdata,
    output logic          done,
    output logic [AW-1:0] entry_addr,
    output logic          err
);
    localparam int unsigned NMEM = 3;

    typedef struct packed {
        ldr_st_e         st;
        ldr_tgt_e        tgt;
        logic            jump;
        logic [DW-1:0]   cnt;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   lo;
        logic [NMEM-1:0] we;
        logic [AW-1:0]   waddr;
        logic [DW-1:0]   wdata;
        logic            done;
        logic [AW-1:0]   entry;
        logic            err;
    } ldr_reg_t;

    ldr_reg_t r_q, r_d;

    ldr_tgt_e      dec_tgt;
    logic          dec_jump;
    logic          dec_bad;
    logic [DW-1:0] w_hi;
    logic [DW-1:0] w_lo;
    logic          acc;

    bl_cmd_decode #(.DW(DW)) cmd_dec_i (
        .cmd     (s_data),
        .tgt     (dec_tgt),
        .is_jump (dec_jump),
        .is_bad  (dec_bad)
    );

    bl_word_split #(.DW(DW)) split_i (
        .word    (s_data),
        .hi_half (w_hi),
        .lo_half (w_lo)
    );

    assign s_ready = (r_q.st != ST_SPLO) && (r_q.st != ST_HALT);
    assign acc     = s_valid && s_ready;

    always_comb begin
        r_d    = r_q;
        r_d.we = '0;
        case (r_q.st)
            ST_PSIZE: if (acc) begin
                r_d.cnt = s_data;
                r_d.st  = ST_POFF;
            end
            ST_POFF: if (acc) begin
                r_d.addr = s_data[AW-1:0];
                r_d.tgt  = TGT_P;
                r_d.st   = (r_q.cnt == '0) ? ST_CMD : ST_DATA;
            end
            ST_CMD: if (acc) begin
                if (dec_bad) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_HALT;
                end else begin
                    r_d.tgt  = dec_tgt;
                    r_d.jump = dec_jump;
                    r_d.st   = ST_ADDR;
                end
            end
            ST_ADDR: if (acc) begin
                r_d.addr = s_data[AW-1:0];
                if (r_q.jump) begin
                    r_d.done  = 1'b1;
                    r_d.entry = s_data[AW-1:0];
                    r_d.st    = ST_HALT;
                end else begin
                    r_d.st = ST_SIZE;
                end
            end
            ST_SIZE: if (acc) begin
                r_d.cnt = s_data;
                r_d.st  = (s_data == '0) ? ST_CMD : ST_DATA;
            end
            ST_DATA: if (acc) begin
                r_d.waddr = r_q.addr;
                r_d.addr  = r_q.addr + AW'(1);
                case (r_q.tgt)
                    TGT_P:   r_d.we[0] = 1'b1;
                    TGT_X:   r_d.we[1] = 1'b1;
                    default: r_d.we[2] = 1'b1;
                endcase
                if (r_q.tgt == TGT_YS) begin
                    r_d.wdata = w_hi;
                    r_d.lo    = w_lo;
                    r_d.st    = ST_SPLO;
                end else begin
                    r_d.wdata = s_data;
                    r_d.cnt   = r_q.cnt - DW'(1);
                    if (r_q.cnt == DW'(1)) r_d.st = ST_CMD;
                end
            end
            ST_SPLO: begin
                r_d.we[2] = 1'b1;
                r_d.waddr = r_q.addr;
                r_d.wdata = r_q.lo;
                r_d.addr  = r_q.addr + AW'(1);
                r_d.cnt   = r_q.cnt - DW'(1);
                r_d.st    = (r_q.cnt == DW'(1)) ? ST_CMD : ST_DATA;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_PSIZE;
        end else begin
            r_q <= r_d;
        end
    end

    assign p_we       = r_q.we[0];
    assign x_we       = r_q.we[1];
    assign y_we       = r_q.we[2];
    assign p_addr     = r_q.waddr;
    assign x_addr     = r_q.waddr;
    assign y_addr     = r_q.waddr;
    assign p_wdata    = r_q.wdata;
    assign x_wdata    = r_q.wdata;
    assign y_wdata    = r_q.wdata;
    assign done       = r_q.done;
    assign entry_addr = r_q.entry;
    assign err        = r_q.err;

    // R9
    one_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p_we, x_we, y_we}));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && $stable(entry_addr));

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !s_ready && !p_we && !x_we && !y_we);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err && !s_ready && !p_we && !x_we && !y_we);

    // R5
    split_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_ready && !done && !err) |=> y_we && (y_addr == $past(y_addr) + AW'(1)));

    // R5
    split_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_we && r_q.tgt == TGT_YS) |-> (y_wdata[DW-1:DW/2] == '0));

endmodule

// File: tb/boot_chunk_loader_tb_top.sv
`timescale 1ns/1ps
module boot_chunk_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic [23:0] s_data = '0;
    logic        s_ready;
    logic        p_we, x_we, y_we;
    logic [23:0] p_addr, x_addr, y_addr;
    logic [23:0] p_wdata, x_wdata, y_wdata;
    logic        done, err;
    logic [23:0] entry_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    boot_chunk_loader dut_i (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
        .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
        .y_we(y_we), .y_addr(y_addr), .y_wdata(y_wdata),
        .done(done), .entry_addr(entry_addr), .err(err)
    );

    localparam int NSTR = 28;
    localparam logic [23:0] STREAM [NSTR] = '{
        24'd3, 24'h000100, 24'hAAAAA1, 24'hAAAAA2, 24'hAAAAA3,
        24'd1, 24'h000200, 24'd2, 24'h111111, 24'h222222,
        24'd2, 24'h000300, 24'd0,
        24'd2, 24'h000310, 24'd1, 24'h333333,
        24'd3, 24'h000400, 24'd2, 24'hABC123, 24'h456DEF,
        24'd0, 24'h000050, 24'd1, 24'h777777,
        24'd4, 24'h000D0C
    };

    // {target(0=P,1=X,2=Y), address, data}
    localparam int NEXP = 11;
    localparam logic [49:0] EXPW [NEXP] = '{
        {2'd0, 24'h000100, 24'hAAAAA1},
        {2'd0, 24'h000101, 24'hAAAAA2},
        {2'd0, 24'h000102, 24'hAAAAA3},
        {2'd1, 24'h000200, 24'h111111},
        {2'd1, 24'h000201, 24'h222222},
        {2'd2, 24'h000310, 24'h333333},
        {2'd2, 24'h000400, 24'h000ABC},
        {2'd2, 24'h000401, 24'h000123},
        {2'd2, 24'h000402, 24'h000456},
        {2'd2, 24'h000403, 24'h000DEF},
        {2'd0, 24'h000050, 24'h777777}
    };

    logic [49:0] wlog [32];
    int nlog = 0;
    bit log_en = 1'b0;

    always @(negedge clk) begin
        if (log_en && nlog < 32) begin
            if (p_we) begin wlog[nlog] = {2'd0, p_addr, p_wdata}; nlog++; end
            if (x_we) begin wlog[nlog] = {2'd1, x_addr, x_wdata}; nlog++; end
            if (y_we) begin wlog[nlog] = {2'd2, y_addr, y_wdata}; nlog++; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] w);
        int t;
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = w;
        t = 0;
        while (!s_ready && t < 50) begin
            @(negedge clk);
            t++;
        end
        chk(t < 50, "R10 send stalled", 64'(t), 64'd0);
        @(posedge clk);
    endtask

    task automatic idle_at_negedge();
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        s_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int nbefore;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(!p_we && !x_we && !y_we, "R1 write enables", {61'd0, p_we, x_we, y_we}, 64'd0);
        chk(s_ready, "R1 ready", 64'(s_ready), 64'd1);
        chk(!done && !err, "R1 done/err", {62'd0, done, err}, 64'd0);

        // Vector table walk with idle gaps (R2 R4 R5 R6 R8 R10)
        log_en = 1'b1;
        for (int i = 0; i < NSTR; i++) begin
            send(STREAM[i]);
            if (i % 4 == 3) begin
                idle_at_negedge();
                repeat (2) @(negedge clk);
            end
        end
        idle_at_negedge();
        repeat (3) @(negedge clk);
        chk(done, "R6 done", 64'(done), 64'd1);
        chk(entry_addr == 24'h000D0C, "R6 entry", 64'(entry_addr), 64'hD0C);
        chk(!s_ready, "R6 ready low", 64'(s_ready), 64'd0);
        nbefore = nlog;
        s_valid = 1'b1;
        s_data  = 24'h000001;
        repeat (5) @(negedge clk);
        s_valid = 1'b0;
        chk(nlog == nbefore, "R6 no writes after jump", 64'(nlog), 64'(nbefore));
        chk(done && entry_addr == 24'h000D0C, "R6 done held", 64'(entry_addr), 64'hD0C);
        chk(nlog == NEXP, "R2 R4 R5 R8 write count", 64'(nlog), 64'(NEXP));
        for (int k = 0; k < NEXP; k++) begin
            chk(wlog[k] == EXPW[k], "R2 R4 R5 R8 write entry", 64'(wlog[k]), 64'(EXPW[k]));
        end
        log_en = 1'b0;

        // R9 write latency: one cycle after acceptance
        do_reset();
        send(24'd1);
        send(24'h000100);
        send(24'h123456);
        @(negedge clk);
        s_valid = 1'b0;
        chk(p_we && p_addr == 24'h000100 && p_wdata == 24'h123456, "R9 latency",
            {15'd0, p_we, p_addr, p_wdata}, {15'd0, 1'b1, 24'h000100, 24'h123456});
        chk(!x_we && !y_we, "R9 single enable", {62'd0, x_we, y_we}, 64'd0);

        // R3 empty preamble, then X chunk, then R7 bad command
        do_reset();
        log_en = 1'b1;
        nlog = 0;
        send(24'd0);
        send(24'h000100);
        send(24'd1);
        send(24'h000020);
        send(24'd1);
        send(24'h000055);
        idle_at_negedge();
        @(negedge clk);
        chk(nlog == 1 && wlog[0] == {2'd1, 24'h000020, 24'h000055}, "R3 empty preamble",
            64'(wlog[0]), 64'({2'd1, 24'h000020, 24'h000055}));
        send(24'd7);
        idle_at_negedge();
        chk(err, "R7 err set", 64'(err), 64'd1);
        chk(!s_ready, "R7 ready low", 64'(s_ready), 64'd0);
        s_valid = 1'b1;
        s_data  = 24'd0;
        repeat (4) @(negedge clk);
        s_valid = 1'b0;
        chk(err && nlog == 1, "R7 halted", 64'(nlog), 64'd1);
        log_en = 1'b0;

        // R5 split stall and ordering
        do_reset();
        send(24'd0);
        send(24'h000100);
        send(24'd3);
        send(24'h000010);
        send(24'd1);
        send(24'hFFF001);
        @(negedge clk);
        s_valid = 1'b0;
        chk(y_we && y_addr == 24'h000010 && y_wdata == 24'h000FFF, "R5 upper half",
            {15'd0, y_we, y_addr, y_wdata}, {15'd0, 1'b1, 24'h000010, 24'h000FFF});
        chk(!s_ready, "R5 stall", 64'(s_ready), 64'd0);
        @(negedge clk);
        chk(y_we && y_addr == 24'h000011 && y_wdata == 24'h000001, "R5 lower half",
            {15'd0, y_we, y_addr, y_wdata}, {15'd0, 1'b1, 24'h000011, 24'h000001});
        chk(s_ready, "R5 ready back", 64'(s_ready), 64'd1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule